// File: doc/BRIEF.md
# Master Serial Configuration Loader

This block is the receiving end of a serial configuration link in which the loader, not the memory, runs the transfer. It reads three mode-select inputs. When all three are low, it runs a fixed sequence. First it holds a reset line towards the external serial memory so that the memory's address counter starts from zero. Then it sources a temporary configuration clock. It shifts one data bit into an internal register on each rising edge of that clock. When the register is full, it stops the clock and raises a completion line that deselects the memory.

Loading begins on its own when the power-on reset is released. It also begins on a reprogram request, which is honoured in any state. A power-on reset in the middle of a transfer, as after a supply dip, restarts the whole sequence from the memory-reset phase. Outside serial mode the loader stays quiet and never produces a clock edge.

Top module: `serial_cfg_loader`

## Requirements
- R1: While `rst_n` is low, `cclk`, `init_o`, `done_o`, `loaded` and `cfg_word` are all 0.
- R2: If `mode` is not 3'b000, the loader stays idle: `cclk` never rises and `init_o` and `done_o` stay low. This also holds after a reprogram request.
- R3: With `mode` equal to 3'b000, `init_o` goes high one clock after reset release or after a `reprog` pulse. It stays high for exactly `INIT_CYCLES` clocks, and `cclk` stays low during that time.
- R4: `cclk` toggles only during loading, with a period of 2*`CCLK_HALF` clocks. Outside loading it is held low.
- R5: `din` is captured on each rising edge of `cclk` and shifted in MSB-first. The first received bit ends up in `cfg_word[CFG_BITS-1]` and the last in `cfg_word[0]`.
- R6: After exactly `CFG_BITS` rising edges of `cclk`, the next falling edge of `cclk` ends loading. At that point `done_o` and `loaded` go high and stay high, and `cclk` stays low.
- R7: Once `done_o` is high, changes on `din` have no effect, and `cfg_word` holds its value.
- R8: A `reprog` pulse in any state, including mid-load and done, clears `cfg_word`, the bit count, `done_o` and `loaded` on the next clock. A following load then completes with the correct full length.
- R9: A power-on reset during loading abandons the transfer. After release, the complete sequence reruns, starting with the `init_o` phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| mode | input | 3 | Mode-select pins; 3'b000 selects serial loading |
| reprog | input | 1 | Reprogram request, one clock pulse |
| din | input | 1 | Serial data from memory |
| cclk | output | 1 | Generated configuration clock |
| init_o | output | 1 | Memory address-counter reset, high active |
| done_o | output | 1 | Completion; deselects the memory |
| cfg_word | output | CFG_BITS | Assembled configuration word |
| loaded | output | 1 | Full word received |

## Verification
The assertions assume that `mode` is stable whenever `reprog` is pulsed and while the loader sits idle. They also assume that `reprog` is a single-clock pulse. The bench changes `mode` only while `rst_n` is low and drives `reprog` high for exactly one clock. It updates `din` only on falling clock edges while `cclk` is low or has just risen, so the data is settled well before each capture. After completion, `din` is returned to 1, as a pull-up would leave it, before any toggling that tests it is ignored.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int CFG_BITS    = 32,
  parameter int INIT_CYCLES = 8,
  parameter int CCLK_HALF   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          mode,
  input  logic                reprog,
  input  logic                din,
  output logic                cclk,
  output logic                init_o,
  output logic                done_o,
  output logic [CFG_BITS-1:0] cfg_word,
  output logic                loaded
);
  localparam int BW = $clog2(CFG_BITS + 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam int DW = $clog2(CCLK_HALF + 1);

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_LOAD, S_DONE} st_t;

  st_t           st;
  logic [BW-1:0] nbits;
  logic [IW-1:0] icnt;
  logic [DW-1:0] div;
  logic          cclk_q;

  wire serial_sel = (mode == 3'b000);
  wire tick       = (st == S_LOAD) && (div == DW'(CCLK_HALF - 1));
  wire rise       = tick && !cclk_q;
  wire fall       = tick && cclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      nbits    <= '0;
      icnt     <= '0;
      div      <= '0;
      cclk_q   <= 1'b0;
      cfg_word <= '0;
    end else if (reprog) begin
      st       <= serial_sel ? S_INIT : S_IDLE;
      nbits    <= '0;
      icnt     <= '0;
      div      <= '0;
      cclk_q   <= 1'b0;
      cfg_word <= '0;
    end else begin
      case (st)
        S_IDLE: if (serial_sel) begin
          st   <= S_INIT;
          icnt <= '0;
        end
        S_INIT: if (icnt == IW'(INIT_CYCLES - 1)) begin
          st     <= S_LOAD;
          div    <= '0;
          cclk_q <= 1'b0;
        end else begin
          icnt <= icnt + 1'b1;
        end
        S_LOAD: begin
          div <= tick ? '0 : div + 1'b1;
          if (tick) cclk_q <= ~cclk_q;
          if (rise) begin
            cfg_word <= {cfg_word[CFG_BITS-2:0], din};
            nbits    <= nbits + 1'b1;
          end
          if (fall && nbits == BW'(CFG_BITS)) st <= S_DONE;
        end
        S_DONE: ;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cclk   = cclk_q;
  assign init_o = (st == S_INIT);
  assign done_o = (st == S_DONE);
  assign loaded = (st == S_DONE) && (nbits == BW'(CFG_BITS));

  // R4
  cclk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_LOAD) |-> !cclk_q);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !serial_sel) |=> (st == S_IDLE && !cclk_q));

  // R8
  reprog_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reprog && serial_sel) |=> (init_o && nbits == '0 && !loaded && cfg_word == '0));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !reprog) |=> (done_o && $stable(cfg_word)));

  // R6
  bit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD) |-> (nbits <= BW'(CFG_BITS)));

  // R3
  init_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_o |-> (!done_o && !cclk_q));
endmodule

// File: tb/sim_serial_cfg_loader.sv
`timescale 1ns/1ps
module sim_serial_cfg_loader;
  localparam int W = 16, NI = 3, HF = 2;
  localparam logic [W-1:0] PATS [5] = '{16'hA5C3, 16'h0000, 16'hFFFF, 16'h8001, 16'h6B2E};
  localparam logic [W-1:0] EXPS [5] = '{16'hA5C3, 16'h0000, 16'hFFFF, 16'h8001, 16'h6B2E};

  logic clk = 0, rst_n = 0, reprog = 0, din = 1;
  logic [2:0] mode = 3'b000;
  logic cclk, init_o, done_o, loaded;
  logic [W-1:0] cfg_word;
  int total = 0, fails = 0;

  always #10 clk = ~clk;

  serial_cfg_loader #(.CFG_BITS(W), .INIT_CYCLES(NI), .CCLK_HALF(HF)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .reprog(reprog), .din(din),
    .cclk(cclk), .init_o(init_o), .done_o(done_o), .cfg_word(cfg_word), .loaded(loaded));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_load(input logic [W-1:0] pat, input bit pulse, input int stop_at,
                          output int ninit, output int nrise, output int badgap);
    bit prev = 0;
    int gap = 0;
    if (pulse) begin
      reprog = 1;
      @(negedge clk);
      reprog = 0;
    end
    ninit = 0; nrise = 0; badgap = 0;
    din = pat[W-1];
    for (int t = 0; t < 2000 && !done_o && nrise < stop_at; t++) begin
      if (init_o) begin
        ninit++;
        if (cclk) badgap++;
      end
      if (cclk && !prev) begin
        nrise++;
        if (nrise > 1 && gap != 2*HF) badgap++;
        gap = 0;
      end
      gap++;
      prev = cclk;
      din = (nrise < W) ? pat[W-1-nrise] : 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int ni, nr, bg;
    logic [W-1:0] held;

    mode = 3'b000;
    repeat (3) @(negedge clk);
    // R1
    chk({cclk, init_o, done_o, loaded} == 4'b0 && cfg_word == '0, "R1", {cclk, init_o, done_o, loaded}, 0);

    rst_n = 1;
    run_load(PATS[0], 0, W + 1, ni, nr, bg);
    // R3 power-up start
    chk(ni == NI, "R3", ni, NI);
    chk(nr == W, "R6", nr, W);
    chk(bg == 0, "R4", bg, 0);
    chk(cfg_word == EXPS[0], "R5", cfg_word, EXPS[0]);
    chk(done_o && loaded && !cclk, "R6", {done_o, loaded, cclk}, 3'b110);

    for (int i = 1; i < 5; i++) begin
      run_load(PATS[i], 1, W + 1, ni, nr, bg);
      chk(ni == NI, "R3", ni, NI);
      chk(nr == W, "R6", nr, W);
      chk(bg == 0, "R4", bg, 0);
      chk(cfg_word == EXPS[i], "R5", cfg_word, EXPS[i]);
      chk(done_o && loaded, "R6", {done_o, loaded}, 2'b11);
    end

    // R7: din ignored after completion
    held = cfg_word;
    for (int k = 0; k < 20; k++) begin
      din = k[0];
      @(negedge clk);
    end
    din = 1;
    chk(cfg_word == held && done_o && !cclk, "R7", cfg_word, held);

    // R8: reprog mid-load clears and restarts
    run_load(16'hFFFF, 1, 6, ni, nr, bg);
    reprog = 1;
    @(negedge clk);
    reprog = 0;
    chk(init_o && !loaded && !done_o && cfg_word == '0, "R8", cfg_word, 0);
    run_load(16'h3C5A, 0, W + 1, ni, nr, bg);
    chk(nr == W && cfg_word == 16'h3C5A && loaded, "R8", cfg_word, 16'h3C5A);

    // R9: reset during load restarts from init phase
    run_load(16'hFFFF, 1, 7, ni, nr, bg);
    rst_n = 0;
    @(negedge clk);
    chk(!cclk && cfg_word == '0, "R9", cfg_word, 0);
    rst_n = 1;
    run_load(16'h1234, 0, W + 1, ni, nr, bg);
    chk(ni == NI && cfg_word == 16'h1234 && loaded, "R9", cfg_word, 16'h1234);

    // R2: non-serial mode stays idle
    rst_n = 0;
    mode = 3'b010;
    @(negedge clk);
    rst_n = 1;
    run_load(16'hFFFF, 0, W + 1, ni, nr, bg);
    chk(nr == 0 && ni == 0 && !done_o, "R2", nr, 0);
    run_load(16'hFFFF, 1, W + 1, ni, nr, bg);
    chk(nr == 0 && ni == 0 && !done_o && !init_o, "R2", nr, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule